// File: doc/BRIEF.md
# Signed multiply-accumulate write path

This block turns a 32-bit cache word into a 32-bit memory write. The cache holds two signed 16-bit operands. The low half is operand A and the high half is operand B, each stored little-endian. When the CPU writes the data port, the block forms the signed product A*B. It emits either that product or a running 32-bit accumulator updated by it, as a single 32-bit word write toward memory. When the multiplier is switched off, the cache word itself is written out unchanged.

A CPU builds a sum of products as follows:
- It sets the accumulate bit.
- It pulses the clear strobe.
- It then writes the data port once per term.

The memory side receives one word per data-port write. Address generation and cache loading live outside the block. The multiply is registered, so every write leaves the block exactly two clocks after the strobe. Strobes on consecutive clocks are accepted, and each one yields its own word.

Top module: `smac_wr`

## Requirements
- R1: After reset deassertion no write is emitted until a data-port write occurs, and the accumulator starts at 0.
- R2: Operand A is cache bits [15:0] and operand B is cache bits [31:16], both two's complement; the product is the full 32-bit two's complement A*B.
- R3: Every cycle with `wr_i` high yields exactly one cycle of `mem_we_o` high two clocks later; `mem_we_o` is low otherwise.
- R4: With multiply on and accumulate off, the written word is the product, and the accumulator keeps its value.
- R5: With multiply and accumulate on and `sub_i` low, the accumulator becomes accumulator + product, and that new value is the written word.
- R6: With multiply and accumulate on and `sub_i` high, the accumulator becomes accumulator - product, and that new value is the written word.
- R7: A cycle with `acc_clr_i` high sets the accumulator to 0. If a write is strobed in the same cycle, the clear takes effect before that write.
- R8: With multiply off, the cache word is written unchanged, and `acc_en_i`/`sub_i` have no effect on the word or the accumulator.
- R9: Accumulation wraps modulo 2^32 with no flag.
- R10: Writes strobed on consecutive cycles each produce their own correct word on consecutive cycles, and the accumulation chains through them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cache_i | input | 32 | Cache word: operand A low half, operand B high half |
| wr_i | input | 1 | Data-port write strobe |
| mul_en_i | input | 1 | 1: write product/accumulator; 0: write cache word |
| acc_en_i | input | 1 | 1: update and write accumulator |
| sub_i | input | 1 | 1: accumulation subtracts the product |
| acc_clr_i | input | 1 | Accumulator clear strobe |
| mem_we_o | output | 1 | 32-bit memory write enable |
| mem_wdata_o | output | 32 | 32-bit memory write data |

## Verification
The bench builds the block with its defaults: 16-bit operands and a 32-bit result. At that width the extreme operand -32768 is reachable, and -32768 times -32768 gives 0x40000000. Four such accumulated terms carry past bit 31, which exercises the modulo wrap. Mixed-sign operands, subtraction, and clears issued alongside a write are run back to back. This checks that the pipelined clear and accumulation stay in order with the writes.

// File: rtl/smac_pkg.sv
package smac_pkg;
  typedef struct packed {
    logic mul;
    logic acc;
    logic sub;
  } smac_ctrl_t;
endpackage

// File: rtl/smac_mul.sv
module smac_mul
  import smac_pkg::*;
#(
  parameter int  OP_W       = 16,
  parameter bit  SIGNED_OPS = 1'b1,
  localparam int RES_W      = 2 * OP_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [RES_W-1:0] cache_i,
  input  logic             wr_i,
  input  smac_ctrl_t       ctrl_i,
  input  logic             clr_i,
  output logic             v_o,
  output smac_ctrl_t       ctrl_o,
  output logic             clr_o,
  output logic [RES_W-1:0] data_o
);
  logic [RES_W-1:0] prod;

  generate
    if (SIGNED_OPS) begin : g_signed
      logic signed [OP_W-1:0]  op_a, op_b;
      logic signed [RES_W-1:0] p_s;
      always_comb begin
        op_a = cache_i[OP_W-1:0];
        op_b = cache_i[RES_W-1:OP_W];
        p_s  = op_a * op_b;
        prod = p_s;
      end
    end else begin : g_unsigned
      always_comb prod = cache_i[OP_W-1:0] * cache_i[RES_W-1:OP_W];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_o    <= 1'b0;
      ctrl_o <= '0;
      clr_o  <= 1'b0;
      data_o <= '0;
    end else begin
      v_o   <= wr_i;
      clr_o <= clr_i;
      if (wr_i) begin
        ctrl_o <= ctrl_i;
        data_o <= ctrl_i.mul ? prod : cache_i;
      end
    end
  end

  // R3
  stage_v_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) wr_i |=> v_o);
  // R3
  stage_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !wr_i |=> !v_o);
endmodule

// File: rtl/smac_acc.sv
module smac_acc
  import smac_pkg::*;
#(
  parameter int RES_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             v_i,
  input  smac_ctrl_t       ctrl_i,
  input  logic             clr_i,
  input  logic [RES_W-1:0] data_i,
  output logic             we_o,
  output logic [RES_W-1:0] wdata_o
);
  logic [RES_W-1:0] acc_q, base, sum;
  logic             do_acc;

  always_comb begin
    base   = clr_i ? '0 : acc_q;
    do_acc = v_i && ctrl_i.mul && ctrl_i.acc;
    sum    = ctrl_i.sub ? base - data_i : base + data_i;  // wraps mod 2^RES_W
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      we_o    <= 1'b0;
      wdata_o <= '0;
    end else begin
      we_o  <= v_i;
      acc_q <= do_acc ? sum : base;
      if (v_i) wdata_o <= do_acc ? sum : data_i;
    end
  end

  // R3
  we_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) v_i |=> we_o);
  // R3
  we_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !v_i |=> !we_o);
  // R5
  acc_wr_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) do_acc |=> wdata_o == acc_q);
  // R7
  acc_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) (clr_i && !do_acc) |=> acc_q == '0);
  // R4
  acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                                 (!clr_i && !do_acc) |=> acc_q == $past(acc_q));
endmodule

// File: rtl/smac_wr.sv
module smac_wr
  import smac_pkg::*;
#(
  parameter int  OP_W  = 16,
  localparam int RES_W = 2 * OP_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [RES_W-1:0] cache_i,
  input  logic             wr_i,
  input  logic             mul_en_i,
  input  logic             acc_en_i,
  input  logic             sub_i,
  input  logic             acc_clr_i,
  output logic             mem_we_o,
  output logic [RES_W-1:0] mem_wdata_o
);
  smac_ctrl_t       ctrl_in, ctrl_s1;
  logic             v_s1, clr_s1;
  logic [RES_W-1:0] data_s1;

  always_comb begin
    ctrl_in.mul = mul_en_i;
    ctrl_in.acc = acc_en_i;
    ctrl_in.sub = sub_i;
  end

  smac_mul #(.OP_W(OP_W), .SIGNED_OPS(1'b1)) u_mul (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cache_i(cache_i),
    .wr_i   (wr_i),
    .ctrl_i (ctrl_in),
    .clr_i  (acc_clr_i),
    .v_o    (v_s1),
    .ctrl_o (ctrl_s1),
    .clr_o  (clr_s1),
    .data_o (data_s1)
  );

  smac_acc #(.RES_W(RES_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .v_i    (v_s1),
    .ctrl_i (ctrl_s1),
    .clr_i  (clr_s1),
    .data_i (data_s1),
    .we_o   (mem_we_o),
    .wdata_o(mem_wdata_o)
  );
endmodule

// File: tb/sim_smac_wr.sv
module sim_smac_wr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cache = '0;
  logic        wr = 1'b0, mul = 1'b0, acc = 1'b0, sub = 1'b0, clr = 1'b0;
  logic        we;
  logic [31:0] wdata;

  int total = 0, bad = 0, cyc = 0;
  logic [31:0] acc_m = '0;
  logic [31:0] exp_q[$];
  int          due_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  smac_wr u0 (
    .clk_i(clk), .rst_ni(rst_n), .cache_i(cache), .wr_i(wr), .mul_en_i(mul),
    .acc_en_i(acc), .sub_i(sub), .acc_clr_i(acc_clr_w), .mem_we_o(we), .mem_wdata_o(wdata)
  );
  logic acc_clr_w;
  assign acc_clr_w = clr;

  function automatic logic [31:0] prod(input logic [31:0] c);
    logic signed [15:0] a, b;
    logic signed [31:0] p;
    a = c[15:0]; b = c[31:16];
    p = a * b;
    return p;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] ex);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, ex);
    end
  endtask

  // driver: one cycle of stimulus, model update, scoreboard push
  task automatic op(input logic [31:0] c, input bit w, input bit m, input bit a,
                    input bit s, input bit cl, input string tag);
    logic [31:0] e;
    @(posedge clk); #2;
    cache = c; wr = w; mul = m; acc = a; sub = s; clr = cl;
    if (cl) acc_m = '0;
    if (w) begin
      if (!m) e = c;
      else if (!a) e = prod(c);
      else begin
        acc_m = s ? acc_m - prod(c) : acc_m + prod(c);
        e = acc_m;
      end
      exp_q.push_back(e); due_q.push_back(cyc + 2); tag_q.push_back(tag);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) op('0, 0, 0, 0, 0, 0, "idle");
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && we) begin
      if (exp_q.size() == 0) chk(0, "R3 unexpected write", wdata, 32'h0);
      else begin
        logic [31:0] e; int d; string t;
        e = exp_q.pop_front(); d = due_q.pop_front(); t = tag_q.pop_front();
        chk(d == cyc, {t, " R3 latency"}, d, cyc);
        chk(wdata == e, t, wdata, e);
      end
    end else if (rst_n && exp_q.size() != 0 && due_q[0] < cyc)
      begin chk(0, "R3 missing write", 32'h0, exp_q[0]); void'(exp_q.pop_front());
            void'(due_q.pop_front()); void'(tag_q.pop_front()); end
  end

  initial begin
    #2000000;
    chk(0, "watchdog", 32'h0, 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #6 chk(we == 1'b0 && wdata == '0, "R1 reset outputs", {31'h0, we}, 32'h0);
    rst_n = 1'b1;
    idle(3);
    chk(exp_q.size() == 0, "R1 no write after reset", 32'h0, 32'h0);
    // R1: first accumulate without clear starts from 0
    op({16'd3, 16'd7}, 1, 1, 1, 0, 0, "R1 acc starts at 0");
    idle(3);
    // R2/R4: signed products, accumulator untouched
    op({16'hFFFE, 16'd5}, 1, 1, 0, 0, 0, "R2 neg*pos");
    op({16'hFFFD, 16'hFFF9}, 1, 1, 0, 0, 0, "R2 neg*neg");
    op({16'h8000, 16'h8000}, 1, 1, 0, 0, 0, "R2 extreme");
    op({16'h7FFF, 16'h8000}, 1, 1, 0, 0, 0, "R2 max*min");
    op({16'd2, 16'd2}, 1, 1, 1, 0, 0, "R4 acc kept after product writes");
    idle(3);
    // R8: pass-through, acc/sub ignored
    op(32'hDEADBEEF, 1, 0, 1, 1, 0, "R8 raw word");
    op({16'd1, 16'd1}, 1, 1, 1, 0, 0, "R8 acc untouched by raw write");
    // R7: clear alone, then clear with write
    op('0, 0, 0, 0, 0, 1, "clr");
    op({16'd4, 16'd10}, 1, 1, 1, 0, 0, "R7 after clear");
    op({16'd6, 16'd6}, 1, 1, 1, 0, 1, "R7 clear same cycle");
    // R5/R6/R10 back-to-back chain
    op({16'd100, 16'hFF00}, 1, 1, 1, 0, 0, "R5 add");
    op({16'd50, 16'd3}, 1, 1, 1, 1, 0, "R6 sub");
    op({16'hFFFF, 16'd9}, 1, 1, 1, 1, 0, "R6 sub neg");
    op({16'd11, 16'd13}, 1, 1, 1, 0, 0, "R10 chain");
    idle(3);
    // R9: 4 * 0x40000000 wraps to 0
    op({16'h8000, 16'h8000}, 1, 1, 1, 0, 1, "R9 wrap 1");
    for (int i = 0; i < 3; i++) op({16'h8000, 16'h8000}, 1, 1, 1, 0, 0, "R9 wrap");
    op({16'd1, 16'd1}, 1, 1, 1, 0, 0, "R9 after wrap");
    idle(4);
    chk(exp_q.size() == 0, "R3 queue drained", exp_q.size(), 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule